// File: doc/BRIEF.md
# DMA Channel Enable and Interrupt Control Registers

This block is the register-mapped control slice of a multi-channel DMA controller. It holds a global controller enable, one enable bit per channel, and for each interrupt type a per-channel raw event register, a mask register, a masked status view and a write-one-to-clear port. The channel engines drive one-cycle event pulses and transfer-done pulses into it. The block drives the per-channel enables and one combined interrupt line back out.

Software reaches the registers over a simple word-addressed read/write bus. The channel-enable and mask registers take a paired write: bits 15:8 carry a per-channel write-enable and bits 7:0 carry the new values. This lets a single channel be set or cleared without a read-modify-write. Reads are registered, so read data is valid from the clock edge that accepts the read.

Word address map, with `t` as the interrupt type index:
- 0: global configuration.
- 1: channel enable.
- 4+4t: raw.
- 5+4t: status.
- 6+4t: mask.
- 7+4t: clear.

Event input bit `t*N_CH + c` belongs to type `t`, channel `c`.

Top module: `dmac_chan_irq_ctl`

## Requirements
- R1: After reset every channel enable, the global enable, all raw bits and all mask bits are 0, so `ch_en_o` is 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: Bit 0 of the word at address 0 is the global enable; it reads back in bit 0. `ch_en_o` equals the stored channel enables while it is 1 and is all zero while it is 0. The stored enables are kept while the global enable is 0.
- R3: A write to address 1 updates channel c only where wdata bit 8+c is 1; that channel then takes wdata bit c. Channels with a write-enable bit of 0 keep their value.
- R4: A read of address 1 returns the channel enables in bits N_CH-1:0 and zero in all other bits, including bits 15:8.
- R5: A pulse on `ch_done_i[c]` clears channel enable c at the next edge, and it wins over a write that sets the same channel in the same cycle.
- R6: A pulse on an event input sets the matching raw bit at the next edge, whatever the mask and global enable are; raw reads at address 4+4t.
- R7: Writing 1 to bit c at address 7+4t clears raw bit c of type t; a 0 leaves it. An event and a clear of the same bit in the same cycle leave it set.
- R8: The mask at address 6+4t uses the same write-enable byte scheme as R3 and reads with bits 15:8 as zero.
- R9: The status at address 5+4t reads as raw AND mask, and writes to it change nothing.
- R10: `irq_o` is 1 exactly while some raw bit of some type has its mask bit at 1, and it follows the register state of the same cycle.
- R11: Reads of a clear register return 0, and writes to a raw register change nothing.
- R12: `rdata_o` takes the read value at the edge that accepts a read, holds between reads, and reads 0 at unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | N_IRQ*N_CH | One-cycle interrupt event pulses, type-major |
| ch_done_i | input | N_CH | One-cycle transfer-done pulses |
| ch_en_o | output | N_CH | Channel enables, gated by the global enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every effect is due one edge after its cause:
- a write or event presented in a cycle changes `ch_en_o` and `irq_o` after the following rising edge;
- a read presented in a cycle shows on `rdata_o` after that same edge.

The bench drives inputs at the falling edge and advances its reference model at the next rising edge. It compares all three outputs at the falling edge after that, so each check samples exactly one register stage after its stimulus.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
  localparam int unsigned ADR_CFG_W  = 0;
  localparam int unsigned ADR_CHEN_W = 1;
  localparam int unsigned IRQ_GRP0   = 1;  // type t occupies word group IRQ_GRP0+t (4 words)
  localparam logic [1:0] V_RAW  = 2'd0;
  localparam logic [1:0] V_STAT = 2'd1;
  localparam logic [1:0] V_MASK = 2'd2;
  localparam logic [1:0] V_CLR  = 2'd3;
endpackage

// File: rtl/dmac_chbit_reg.sv
module dmac_chbit_reg #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [N_CH-1:0] wen_i,
  input  logic [N_CH-1:0] val_i,
  input  logic [N_CH-1:0] hw_clr_i,
  output logic [N_CH-1:0] q_o
);
  logic [N_CH-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wr_i) q_d = (q_o & ~wen_i) | (val_i & wen_i);
    q_d = q_d & ~hw_clr_i;  // hardware clear wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  // R3 / R8: bits without write-enable and without clear do not move
  a_r3_unselected_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((q_o ^ $past(q_o)) & ~($past(wen_i) & {N_CH{$past(wr_i)}}) & ~$past(hw_clr_i)) == '0));
  // R5: done clears the bit at the next edge
  a_r5_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i != '0) |=> ((q_o & $past(hw_clr_i)) == '0));
endmodule

// File: rtl/dmac_irq_bank.sv
module dmac_irq_bank #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] evt_i,
  input  logic            clr_wr_i,
  input  logic [N_CH-1:0] clr_i,
  input  logic            mask_wr_i,
  input  logic [N_CH-1:0] mask_wen_i,
  input  logic [N_CH-1:0] mask_val_i,
  output logic [N_CH-1:0] raw_o,
  output logic [N_CH-1:0] mask_o
);
  logic [N_CH-1:0] clr_eff;
  assign clr_eff = clr_wr_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else         raw_o <= (raw_o & ~clr_eff) | evt_i;  // set wins
  end

  dmac_chbit_reg #(.N_CH(N_CH)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mask_wr_i),
    .wen_i    (mask_wen_i),
    .val_i    (mask_val_i),
    .hw_clr_i ('0),
    .q_o      (mask_o)
  );

  // R6 / R7: an event always lands, even against a clear
  a_r6_evt_sets_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_o & $past(evt_i)) == $past(evt_i)));
  // R7 / R11: raw moves only on an event or a clear write
  a_r7_raw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_wr_i && evt_i == '0) |=> $stable(raw_o));
endmodule

// File: rtl/dmac_chan_irq_ctl.sv
module dmac_chan_irq_ctl
  import dmac_ctl_pkg::*;
#(
  parameter int unsigned N_CH   = 8,   // at most 8
  parameter int unsigned N_IRQ  = 3,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned EVT_W = N_CH * N_IRQ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [N_CH-1:0]   ch_done_i,
  output logic [N_CH-1:0]   ch_en_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(ADR_CFG_W);
  localparam logic [ADDR_W-1:0] ADR_CHEN = ADDR_W'(ADR_CHEN_W);

  logic            wr, rd;
  logic [N_CH-1:0] wen, val;
  logic            glob_q;
  logic [N_CH-1:0] chen_q;
  logic [N_CH-1:0] raw_w  [N_IRQ];
  logic [N_CH-1:0] mask_w [N_IRQ];
  logic [N_IRQ-1:0] grp_hit;
  logic [31:0]     rd_mux;
  logic            unused_wd;

  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign wen = wdata_i[8 +: N_CH];
  assign val = wdata_i[0 +: N_CH];
  assign unused_wd = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     glob_q <= 1'b0;
    else if (wr && addr_i == ADR_CFG) glob_q <= wdata_i[0];
  end

  dmac_chbit_reg #(.N_CH(N_CH)) u_chen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr && addr_i == ADR_CHEN),
    .wen_i    (wen),
    .val_i    (val),
    .hw_clr_i (ch_done_i),
    .q_o      (chen_q)
  );

  for (genvar t = 0; t < N_IRQ; t++) begin : g_irq
    localparam logic [ADDR_W-3:0] GRP_ID = (ADDR_W-2)'(IRQ_GRP0 + t);
    assign grp_hit[t] = (addr_i[ADDR_W-1:2] == GRP_ID);
    dmac_irq_bank #(.N_CH(N_CH)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[t*N_CH +: N_CH]),
      .clr_wr_i   (wr && grp_hit[t] && addr_i[1:0] == V_CLR),
      .clr_i      (val),
      .mask_wr_i  (wr && grp_hit[t] && addr_i[1:0] == V_MASK),
      .mask_wen_i (wen),
      .mask_val_i (val),
      .raw_o      (raw_w[t]),
      .mask_o     (mask_w[t])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADR_CFG)       rd_mux[0] = glob_q;
    else if (addr_i == ADR_CHEN) rd_mux[N_CH-1:0] = chen_q;
    for (int t = 0; t < N_IRQ; t++) begin
      if (grp_hit[t]) begin
        case (addr_i[1:0])
          V_RAW:   rd_mux[N_CH-1:0] = raw_w[t];
          V_STAT:  rd_mux[N_CH-1:0] = raw_w[t] & mask_w[t];
          V_MASK:  rd_mux[N_CH-1:0] = mask_w[t];
          default: rd_mux = '0;  // clear view is write-only
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  always_comb begin
    irq_o = 1'b0;
    for (int t = 0; t < N_IRQ; t++) irq_o = irq_o | (|(raw_w[t] & mask_w[t]));
  end

  assign ch_en_o = glob_q ? chen_q : '0;

  // R12: read data holds when no read is accepted
  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  // R2: global disable silences every channel
  a_r2_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADR_CFG && !wdata_i[0]) |=> (ch_en_o == '0));
endmodule

// File: tb/tb_dmac_chan_irq_ctl.sv
module tb_dmac_chan_irq_ctl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic [23:0] evt = '0;
  logic [7:0]  done = '0;
  logic [7:0]  ch_en_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  logic       m_glob = 1'b0;
  logic [7:0] m_chen = '0;
  logic [7:0] m_raw [3] = '{default: '0};
  logic [7:0] m_mask[3] = '{default: '0};
  logic [31:0] m_rd = '0;

  always #5 clk = ~clk;

  dmac_chan_irq_ctl dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .evt_i(evt), .ch_done_i(done),
    .ch_en_o(ch_en_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] model_read(input logic [4:0] a);
    logic [31:0] r = '0;
    int t, v;
    if (a == 5'd0) r[0] = m_glob;
    else if (a == 5'd1) r[7:0] = m_chen;
    else if (a >= 5'd4 && a < 5'd16) begin
      t = (int'(a) - 4) / 4; v = int'(a) % 4;
      case (v)
        0: r[7:0] = m_raw[t];
        1: r[7:0] = m_raw[t] & m_mask[t];
        2: r[7:0] = m_mask[t];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic logic model_irq();
    logic any = 1'b0;
    for (int t = 0; t < 3; t++) any |= |(m_raw[t] & m_mask[t]);
    return any;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    chk(tag, "ch_en_o", 32'(ch_en_o), 32'(m_glob ? m_chen : 8'h00));
    chk(tag, "irq_o", 32'(irq_o), 32'(model_irq()));
    chk(tag, "rdata_o", rdata_o, m_rd);
  endtask

  task automatic cyc(input logic rq, input logic w, input logic [4:0] a, input logic [31:0] d,
                     input logic [23:0] ev, input logic [7:0] dn, input string tag);
    int t, v;
    req = rq; we = w; addr = a; wdata = d; evt = ev; done = dn;
    @(posedge clk);
    if (rq && !w) m_rd = model_read(a);
    if (rq && w) begin
      if (a == 5'd0) m_glob = d[0];
      else if (a == 5'd1) m_chen = (m_chen & ~d[15:8]) | (d[7:0] & d[15:8]);
      else if (a >= 5'd4 && a < 5'd16) begin
        t = (int'(a) - 4) / 4; v = int'(a) % 4;
        if (v == 2) m_mask[t] = (m_mask[t] & ~d[15:8]) | (d[7:0] & d[15:8]);
        if (v == 3) m_raw[t] = m_raw[t] & ~d[7:0];
      end
    end
    m_chen = m_chen & ~dn;
    for (int k = 0; k < 3; k++) m_raw[k] = m_raw[k] | ev[k*8 +: 8];
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0; done = '0;
    check_outs(tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, '0, '0, tag);
  endtask
  task automatic rdx(input logic [4:0] a, input string tag);
    cyc(1'b1, 1'b0, a, '0, '0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_outs("R1");
    rdx(5'd1, "R1"); rdx(5'd6, "R1"); rdx(5'd4, "R1");

    // global enable and channel enables
    wr(5'd1, 32'h0000_0505, "R2");        // stored while global off
    wr(5'd0, 32'h1, "R2");
    rdx(5'd0, "R2");
    wr(5'd0, 32'h0, "R2");
    wr(5'd0, 32'h1, "R2");
    wr(5'd1, 32'h0000_0CFF, "R3");        // only ch2, ch3 set
    wr(5'd1, 32'h0000_0100, "R3");        // clear ch0 only
    rdx(5'd1, "R4");
    wr(5'd1, 32'hFFFF_FF00 | 32'h0000_0001, "R4");
    rdx(5'd1, "R4");
    cyc(1'b1, 1'b1, 5'd1, 32'h0000_0101, '0, 8'h01, "R5");  // done beats set
    cyc(1'b0, 1'b0, 5'd0, '0, '0, 8'h84, "R5");

    // interrupts
    cyc(1'b0, 1'b0, 5'd0, '0, 24'h00_0800, '0, "R6");       // type1 ch3
    rdx(5'd8, "R6");
    rdx(5'd9, "R9");
    wr(5'd10, 32'h0000_0808, "R8");
    rdx(5'd10, "R8");
    rdx(5'd9, "R9");
    wr(5'd9, 32'h0000_FFFF, "R9");
    rdx(5'd9, "R10");
    cyc(1'b1, 1'b1, 5'd11, 32'h0000_0008, 24'h00_0800, '0, "R7");  // set wins
    wr(5'd11, 32'h0000_0000, "R7");
    rdx(5'd8, "R7");
    wr(5'd11, 32'h0000_0008, "R10");
    rdx(5'd11, "R11");
    wr(5'd4, 32'h0000_FFFF, "R11");
    rdx(5'd4, "R11");
    rdx(5'd31, "R12");
    cyc(1'b0, 1'b0, 5'd1, '0, '0, '0, "R12");

    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  a;
      logic [31:0] d;
      a = ($urandom % 8 == 0) ? 5'($urandom) : 5'($urandom % 16);
      d = $urandom;
      cyc(1'($urandom), 1'($urandom), a, d, 24'($urandom & $urandom & $urandom),
          8'($urandom & $urandom & $urandom), "random R3 R5 R7 R8 R9 R10 R12");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule